// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block sits at the address input of a synchronous burst SRAM. It registers an external address when a burst is started and then produces the following addresses of the burst on chip. The memory datapath receives the current array address and a flag that says the device is selected. Only the low `CNT_W` address bits (two by default, so four locations) move during a burst. The upper bits stay as loaded.

Either of two address strobes can start a burst. One is processor-side and the other is controller-side. An advance input then steps through the burst. A strap input picks the step order: linear wrap-around counting or an XOR-interleaved sequence. The order is captured when each burst starts. A fresh external address may be loaded on every clock, so random accesses run back to back with no idle cycles.

All inputs are sampled on the rising clock edge. All outputs come from registers and change after the edge that samples the command.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets: `arr_addr` becomes 0, `sel_valid` becomes 0, and interleaved order is selected.
- R2: When `strb_proc` is 1 and `ce` is 1 at an edge, `ext_addr` is loaded and `sel_valid` is 1 after that edge. This happens whatever `strb_ctrl` and `adv` are doing.
- R3: When `strb_ctrl` is 1, `ce` is 1 and no R2 load takes place, `ext_addr` is loaded and `sel_valid` is 1 after that edge.
- R4: When `ce` is 0, `strb_proc` is ignored, and the cycle behaves as if `strb_proc` were 0.
- R5: When `strb_ctrl` is 1 and `ce` is 0, the block deselects: `sel_valid` becomes 0 and `arr_addr` keeps its value.
- R6: With `order_sel` at 0 when the burst starts (linear order), each advance adds 1 modulo 4 to the low two bits of `arr_addr`. The upper bits never change during a burst.
- R7: With `order_sel` at 1 when the burst starts (interleaved order, the default strap), the low two bits after k advances equal the loaded low bits XOR k, for k = 0, 1, 2, 3.
- R8: When no strobe takes effect and `adv` is 0, `arr_addr` and `sel_valid` hold.
- R9: The fourth advance of a burst returns `arr_addr` to the loaded start address, in either order.
- R10: `order_sel` is captured only at a load. A change of `order_sel` during a burst does not alter the sequence.
- R11: A load on every consecutive cycle presents each new `ext_addr` one cycle after it is sampled.
- R12: `adv` has no effect while `sel_valid` is 0.
- R13: A load in the same cycle as `adv` restarts the burst at the new address, and the step is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_addr | input | ADDR_W | External address, sampled on a load |
| strb_proc | input | 1 | Processor-side address strobe, qualified by `ce` |
| strb_ctrl | input | 1 | Controller-side address strobe |
| adv | input | 1 | Step to the next burst address |
| ce | input | 1 | Chip enable |
| order_sel | input | 1 | Burst order strap: 0 linear, 1 interleaved (pad pulled to 1) |
| arr_addr | output | ADDR_W | Current array address |
| sel_valid | output | 1 | Device selected, address valid |

## Verification
A load and an advance can fall in the same cycle. The bench provokes this by raising a strobe with a new address while `adv` is still high in the middle of a running burst. It judges the result by checking that the next address is the new start exactly, with no step applied, and that the following advance continues from that start. A second overlap also gets a directed case: an ignored processor strobe with `ce` low while `adv` is high. Here the step must go ahead, and a controller strobe in the same cycle must deselect instead.

// File: rtl/burst_seq_pkg.sv
// Package: shared types of the burst address sequencer.
// Assumes: one command per clock is decoded from the strobes and advance.
package burst_seq_pkg;

    // Command decoded for one clock edge
    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_DESEL = 2'd2,
        CMD_STEP  = 2'd3
    } seq_cmd_e;

    // Burst order; the strap pad is pulled to ORD_INTLV
    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_INTLV  = 1'b1
    } burst_order_e;

endpackage

// File: rtl/burst_ctl.sv
// Module: burst_ctl
// Decodes strobes, chip enable and advance into one command per edge
// and keeps the selected flag.
// Assumes: processor strobe outranks controller strobe; the processor
// strobe is void while chip enable is low.
module burst_ctl
    import burst_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     strb_proc,
    input  logic     strb_ctrl,
    input  logic     adv,
    input  logic     ce,
    output seq_cmd_e cmd,
    output logic     valid_q
);

    logic proc_hit;
    logic ctrl_hit;

    assign proc_hit = strb_proc & ce;
    assign ctrl_hit = strb_ctrl;

    // Priority decode of the command for this edge
    always_comb begin
        if (proc_hit) begin
            cmd = CMD_LOAD;
        end else if (ctrl_hit) begin
            cmd = ce ? CMD_LOAD : CMD_DESEL;
        end else if (adv && valid_q) begin
            cmd = CMD_STEP;
        end else begin
            cmd = CMD_HOLD;
        end
    end

    // Selected flag: set on a load, cleared on a deselect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else if (cmd == CMD_LOAD) begin
            valid_q <= 1'b1;
        end else if (cmd == CMD_DESEL) begin
            valid_q <= 1'b0;
        end
    end

    AST_PROC_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_proc && ce) |=> valid_q); // R2

    AST_CTRL_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_ctrl && !ce) |=> !valid_q); // R5

    AST_NO_STEP_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_q && !strb_proc && !strb_ctrl) |=> !valid_q); // R12

endmodule

// File: rtl/burst_cnt.sv
// Module: burst_cnt
// Burst step counter and captured burst order.
// Assumes: a load clears the count and latches the order strap;
// a step wraps modulo 2**CNT_W.
module burst_cnt
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  seq_cmd_e           cmd,
    input  logic               order_sel,
    output logic [CNT_W-1:0]   cnt_q,
    output burst_order_e       order_q
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    // Count register: clear on load, advance on step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cmd == CMD_LOAD) begin
            cnt_q <= '0;
        end else if (cmd == CMD_STEP) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    // Order register: strap captured at burst start only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order_q <= ORD_INTLV;
        end else if (cmd == CMD_LOAD) begin
            order_q <= burst_order_e'(order_sel);
        end
    end

    AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LOAD) |=> (cnt_q == '0)); // R13

    AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_LOAD) |=> $stable(order_q)); // R10

endmodule

// File: rtl/burst_map.sv
// Module: burst_map
// Maps start bits and step count to the low address bits.
// Assumes: purely combinational; linear adds, interleaved XORs.
module burst_map
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start_lo,
    input  logic [CNT_W-1:0] cnt,
    input  burst_order_e     order,
    output logic [CNT_W-1:0] addr_lo
);

    logic [CNT_W-1:0] lin_lo;
    logic [CNT_W-1:0] ilv_lo;

    assign lin_lo = start_lo + cnt;

    // Interleaved bits: one XOR per address bit
    for (genvar i = 0; i < CNT_W; i++) begin : g_ilv
        assign ilv_lo[i] = start_lo[i] ^ cnt[i];
    end

    // Select the order captured for this burst
    always_comb begin
        addr_lo = (order == ORD_LINEAR) ? lin_lo : ilv_lo;
    end

endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Registers the external address on a load and presents the current
// burst address to the array, with a selected flag.
// Assumes: upper bits are fixed for a burst; only CNT_W low bits move.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strb_proc,
    input  logic              strb_ctrl,
    input  logic              adv,
    input  logic              ce,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              sel_valid
);

    localparam int HI_W = ADDR_W - CNT_W;

    seq_cmd_e         cmd;
    logic             valid_q;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0] cnt_q;
    burst_order_e     order_q;
    logic [CNT_W-1:0] addr_lo;

    burst_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .strb_proc (strb_proc),
        .strb_ctrl (strb_ctrl),
        .adv       (adv),
        .ce        (ce),
        .cmd       (cmd),
        .valid_q   (valid_q)
    );

    burst_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .order_sel (order_sel),
        .cnt_q     (cnt_q),
        .order_q   (order_q)
    );

    // Base address register: loaded from the external bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (cmd == CMD_LOAD) begin
            base_q <= ext_addr;
        end
    end

    burst_map #(.CNT_W(CNT_W)) u_map (
        .start_lo (base_q[CNT_W-1:0]),
        .cnt      (cnt_q),
        .order    (order_q),
        .addr_lo  (addr_lo)
    );

    assign arr_addr  = {base_q[ADDR_W-1:CNT_W], addr_lo};
    assign sel_valid = valid_q;

    AST_LOAD_PRESENTS: assert property (@(posedge clk) disable iff (!rst_n)
        ((strb_proc || strb_ctrl) && ce) |=> (arr_addr == $past(ext_addr))); // R11

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!(strb_proc && ce) && !strb_ctrl && !adv)
        |=> ($stable(arr_addr) && $stable(sel_valid))); // R8

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (!((strb_proc || strb_ctrl) && ce))
        |=> (arr_addr[ADDR_W-1:CNT_W] == $past(arr_addr[ADDR_W-1:CNT_W]))); // R6

    AST_DESEL_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_ctrl && !ce && !(strb_proc && ce)) |=> $stable(arr_addr)); // R5

    initial begin
        AST_WIDTHS_OK: assert (HI_W > 0); // R6
    end

endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          strb_proc = 1'b0;
    logic          strb_ctrl = 1'b0;
    logic          adv = 1'b0;
    logic          ce = 1'b0;
    logic          order_sel = 1'b1;
    logic [AW-1:0] arr_addr;
    logic          sel_valid;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .CNT_W(2)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_addr  (ext_addr),
        .strb_proc (strb_proc),
        .strb_ctrl (strb_ctrl),
        .adv       (adv),
        .ce        (ce),
        .order_sel (order_sel),
        .arr_addr  (arr_addr),
        .sel_valid (sel_valid)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        strb_proc = 1'b0; strb_ctrl = 1'b0; adv = 1'b0;
    endtask

    task automatic load_proc(input logic [AW-1:0] a);
        ext_addr = a; strb_proc = 1'b1; ce = 1'b1; adv = 1'b0;
        tick();
        idle();
    endtask

    task automatic t_reset();
        chk("R1 addr", 32'(arr_addr), 32'h0);
        chk("R1 valid", 32'(sel_valid), 32'h0);
    endtask

    task automatic t_interleave();
        logic [AW-1:0] a = 20'hABCD1;
        order_sel = 1'b1;
        load_proc(a);
        chk("R2 load", 32'(arr_addr), 32'(a));
        chk("R2 valid", 32'(sel_valid), 32'h1);
        for (int k = 1; k < 4; k++) begin
            adv = 1'b1; tick();
            chk("R7 interleave", 32'(arr_addr), 32'({a[AW-1:2], a[1:0] ^ 2'(k)}));
        end
        tick(); adv = 1'b0;
        chk("R9 wrap interleave", 32'(arr_addr), 32'(a));
    endtask

    task automatic t_linear_ctrl();
        logic [AW-1:0] a = 20'h5F00E;
        order_sel = 1'b0;
        ext_addr = a; strb_ctrl = 1'b1; ce = 1'b1; tick(); idle();
        chk("R3 ctrl load", 32'(arr_addr), 32'(a));
        chk("R3 valid", 32'(sel_valid), 32'h1);
        for (int k = 1; k < 4; k++) begin
            adv = 1'b1; tick();
            chk("R6 linear", 32'(arr_addr), 32'({a[AW-1:2], 2'(a[1:0] + 2'(k))}));
        end
        tick(); adv = 1'b0;
        chk("R9 wrap linear", 32'(arr_addr), 32'(a));
    endtask

    task automatic t_order_capture();
        logic [AW-1:0] a = 20'h12341;
        order_sel = 1'b0;
        load_proc(a);
        order_sel = 1'b1;
        adv = 1'b1; tick(); tick(); adv = 1'b0;
        chk("R10 order kept", 32'(arr_addr), 32'(20'h12343));
    endtask

    task automatic t_hold();
        logic [AW-1:0] s = arr_addr;
        idle(); ext_addr = 20'hFFFFF;
        repeat (3) tick();
        chk("R8 hold addr", 32'(arr_addr), 32'(s));
        chk("R8 hold valid", 32'(sel_valid), 32'h1);
    endtask

    task automatic t_ce_low();
        logic [AW-1:0] a = 20'h40000;
        order_sel = 1'b1;
        load_proc(a);
        ce = 1'b0; ext_addr = 20'h7777F; strb_proc = 1'b1; tick(); idle();
        chk("R4 proc ignored", 32'(arr_addr), 32'(a));
        chk("R4 still valid", 32'(sel_valid), 32'h1);
        strb_proc = 1'b1; adv = 1'b1; tick(); idle();
        chk("R4 step goes ahead", 32'(arr_addr), 32'(20'h40001));
        strb_proc = 1'b1; strb_ctrl = 1'b1; adv = 1'b1; tick(); idle();
        chk("R5 deselect valid", 32'(sel_valid), 32'h0);
        chk("R5 deselect addr", 32'(arr_addr), 32'(20'h40001));
        adv = 1'b1; repeat (2) tick(); adv = 1'b0;
        chk("R12 adv ignored", 32'(arr_addr), 32'(20'h40001));
        chk("R12 still off", 32'(sel_valid), 32'h0);
        ce = 1'b1;
    endtask

    task automatic t_back_to_back();
        ce = 1'b1; strb_proc = 1'b1;
        for (int i = 0; i < 4; i++) begin
            ext_addr = 20'(32'h10203 * (i + 1));
            tick();
            chk("R11 back-to-back", 32'(arr_addr), 32'h10203 * (i + 1));
        end
        idle();
    endtask

    task automatic t_load_with_adv();
        logic [AW-1:0] b = 20'h0BEE2;
        order_sel = 1'b0;
        load_proc(20'h33330);
        adv = 1'b1; tick();
        ext_addr = b; strb_proc = 1'b1; tick();
        strb_proc = 1'b0;
        chk("R13 load beats adv", 32'(arr_addr), 32'(b));
        tick(); adv = 1'b0;
        chk("R13 resume", 32'(arr_addr), 32'(20'h0BEE3));
        strb_ctrl = 1'b1; adv = 1'b1; ext_addr = 20'h00002; tick(); idle();
        chk("R13 ctrl load beats adv", 32'(arr_addr), 32'h2);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        t_interleave();
        t_linear_ctrl();
        t_order_capture();
        t_hold();
        t_ce_low();
        t_back_to_back();
        t_load_with_adv();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule